// File: doc/BRIEF.md
# Video Fetch Detector with NOP Forcing

This block watches the CPU's opcode fetches and decides which of them are display-file character fetches rather than real instructions. The decision is taken on a sample strobe that the surrounding timing logic raises a quarter of a 3.5 MHz period after the T3 rising edge. A fetch from the upper half of memory counts as a video fetch only if all of the following hold:

- the opcode read and the read strobe are both active;
- the CPU is not halted;
- data bit 6 is clear;
- when the region-limit option is on, A14 is also high.

When a fetch counts, the CPU gets a NOP in place of the memory data. The character code and its inverse flag are captured for the video shifter. A video-cycle flag is held until the refresh phase that follows has ended.

The block also produces the ROM and RAM chip selects from A14 and the memory request. All outputs are registered on the fast system clock. Every CPU strobe is sampled synchronously on that clock.

Top module: `video_fetch_nop`

## Requirements
- R1: `romcs_n` is low in the cycle after the cycle where `a14`=0 and `mreq_n`=0; otherwise it is high.
- R2: `ramcs_n` is low in the cycle after the cycle where `a14`=1 and `mreq_n`=0; otherwise it is high. The two selects are never low together.
- R3: A fetch qualifies when, in a cycle with `sample_en`=1, all of these hold: `a15`=1, `m1_n`=0, `rd_n`=0, `halt_n`=1 and `dbus_in[6]`=0.
- R4: With `rd_n`=1 at the sample, as in an interrupt-acknowledge cycle, no qualification takes place.
- R5: With `restrict_en`=1, `a14`=1 is also required. With `restrict_en`=0, `a14` has no effect on qualification.
- R6: A fetch never qualifies when `sample_en`=0, or when `m1_n` has already returned high at the sample.
- R7: One cycle after a qualifying sample, `nop_drive_en` is 1 and `dbus_out` is 0x00. Both stay that way while `rd_n` stays low. `nop_drive_en` drops one cycle after `rd_n` is seen high.
- R8: When no NOP is being forced, `dbus_out` equals `dbus_in` delayed by one cycle. An opcode with bit 6 set therefore passes through untouched.
- R9: On a qualifying sample, `char_code` takes `dbus_in[5:0]` and `char_inv` takes `dbus_in[7]`. Both hold until the next qualifying sample.
- R10: `video_cycle` rises one cycle after a qualifying sample and stays high until a `rfsh_done` pulse clears it. If a qualifying sample and `rfsh_done` arrive in the same cycle, the flag is set.
- R11: A synchronous `rst` clears the following: `video_cycle`, `nop_drive_en`, `char_code`, `char_inv` and `dbus_out` go to 0, and both chip selects go high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a15 | input | 1 | CPU address bit 15 |
| a14 | input | 1 | CPU address bit 14 |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| m1_n | input | 1 | Opcode fetch cycle, active low |
| halt_n | input | 1 | Halt status, active low |
| dbus_in | input | 8 | Data seen on the memory side of the bus |
| sample_en | input | 1 | One-cycle strobe at the quarter-period point after T3 rises |
| rfsh_done | input | 1 | One-cycle strobe marking the end of the refresh phase |
| restrict_en | input | 1 | Region-limit option: also require A14 high |
| nop_drive_en | output | 1 | Enable for driving the forced opcode to the CPU |
| dbus_out | output | 8 | Data presented to the CPU (0x00 while forcing) |
| char_code | output | 6 | Latched character code |
| char_inv | output | 1 | Latched inverse-video flag |
| video_cycle | output | 1 | Video fetch in progress, held through refresh |
| romcs_n | output | 1 | ROM chip select, active low |
| ramcs_n | output | 1 | RAM chip select, active low |

## Verification
The bench walks fetch patterns in which exactly one qualifying term is missing at a time. A design that dropped the read-strobe term would treat interrupt acknowledges as video fetches and corrupt the character stream. A design that ignored the region-limit option would steal opcodes from the 32–48K region.

The bench holds the read strobe low across several cycles and changes the incoming data meanwhile. This catches a NOP drive that releases early, which would let the real opcode leak through, or one that releases late, which would clash with the next bus cycle. It also pulses refresh-end together with a new qualifying sample and checks that the set wins. It then checks that captured characters survive fetches that do not qualify.

// File: rtl/vfetch_pkg.sv
package vfetch_pkg;
  typedef struct packed {
    logic a15;
    logic a14;
    logic m1_n;
    logic rd_n;
    logic halt_n;
  } fetch_ctl_t;
endpackage

// File: rtl/vf_qualify.sv
module vf_qualify
  import vfetch_pkg::*;
(
  input  fetch_ctl_t ctl,
  input  logic       test_bit,
  input  logic       restrict_en,
  input  logic       sample_en,
  output logic       hit
);
  logic region_ok;
  logic fetch_ok;

  always_comb begin
    region_ok = ctl.a15 & (~restrict_en | ctl.a14);
    fetch_ok  = ~ctl.m1_n & ~ctl.rd_n & ctl.halt_n & ~test_bit;
    hit       = sample_en & region_ok & fetch_ok;
  end
endmodule

// File: rtl/vf_capture.sv
module vf_capture #(
  parameter int CHAR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              rfsh_done,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              inv_in,
  output logic [CHAR_W-1:0] char_code,
  output logic              char_inv,
  output logic              video_cycle
);
  always_ff @(posedge clk) begin
    if (rst) begin
      char_code   <= '0;
      char_inv    <= 1'b0;
      video_cycle <= 1'b0;
    end else begin
      if (hit) begin
        char_code <= char_in;
        char_inv  <= inv_in;
      end
      if (hit)            video_cycle <= 1'b1;
      else if (rfsh_done) video_cycle <= 1'b0;
    end
  end

  // R9: captured character only changes on a qualifying sample
  p_char_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(hit)) |-> ($stable(char_code) && $stable(char_inv)));

  // R10: refresh end without a new fetch clears the flag
  p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rfsh_done && !hit) |=> !video_cycle);

  // R10: set has priority over clear
  p_flag_set_r10: assert property (@(posedge clk) disable iff (rst)
    hit |=> video_cycle);
endmodule

// File: rtl/vf_bus_force.sv
module vf_bus_force #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] d_in,
  output logic              nop_drive_en,
  output logic [DATA_W-1:0] dbus_out
);
  localparam logic [DATA_W-1:0] NOP_CODE = '0;

  logic force_nxt;

  always_comb force_nxt = hit | (nop_drive_en & ~rd_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      nop_drive_en <= 1'b0;
      dbus_out     <= '0;
    end else begin
      nop_drive_en <= force_nxt;
      dbus_out     <= force_nxt ? NOP_CODE : d_in;
    end
  end

  // R7: forced opcode is zero whenever the drive is enabled
  p_force_zero_r7: assert property (@(posedge clk) disable iff (rst)
    nop_drive_en |-> (dbus_out == NOP_CODE));

  // R7: drive releases after read strobe goes high
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (nop_drive_en && rd_n && !hit) |=> !nop_drive_en);

  // R8: pass-through when idle
  p_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (!nop_drive_en && !hit) |=> (!nop_drive_en && dbus_out == $past(d_in)));
endmodule

// File: rtl/vf_chipsel.sv
module vf_chipsel (
  input  logic clk,
  input  logic rst,
  input  logic a14,
  input  logic mreq_n,
  output logic romcs_n,
  output logic ramcs_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      romcs_n <= 1'b1;
      ramcs_n <= 1'b1;
    end else begin
      romcs_n <= a14 | mreq_n;
      ramcs_n <= ~a14 | mreq_n;
    end
  end

  // R1: low-half memory request selects ROM
  p_rom_sel_r1: assert property (@(posedge clk) disable iff (rst)
    (!a14 && !mreq_n) |=> !romcs_n);

  // R2: high-half memory request selects RAM
  p_ram_sel_r2: assert property (@(posedge clk) disable iff (rst)
    (a14 && !mreq_n) |=> !ramcs_n);

  // R2: selects mutually exclusive
  p_cs_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(!romcs_n && !ramcs_n));
endmodule

// File: rtl/video_fetch_nop.sv
module video_fetch_nop
  import vfetch_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int CHAR_W   = 6,
  parameter int TEST_BIT = 6,
  parameter int INV_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a15,
  input  logic              a14,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              m1_n,
  input  logic              halt_n,
  input  logic [DATA_W-1:0] dbus_in,
  input  logic              sample_en,
  input  logic              rfsh_done,
  input  logic              restrict_en,
  output logic              nop_drive_en,
  output logic [DATA_W-1:0] dbus_out,
  output logic [CHAR_W-1:0] char_code,
  output logic              char_inv,
  output logic              video_cycle,
  output logic              romcs_n,
  output logic              ramcs_n
);
  fetch_ctl_t ctl;
  logic       hit;

  always_comb begin
    ctl.a15    = a15;
    ctl.a14    = a14;
    ctl.m1_n   = m1_n;
    ctl.rd_n   = rd_n;
    ctl.halt_n = halt_n;
  end

  vf_qualify u_qual (
    .ctl(ctl), .test_bit(dbus_in[TEST_BIT]), .restrict_en(restrict_en),
    .sample_en(sample_en), .hit(hit)
  );

  vf_capture #(.CHAR_W(CHAR_W)) u_cap (
    .clk(clk), .rst(rst), .hit(hit), .rfsh_done(rfsh_done),
    .char_in(dbus_in[CHAR_W-1:0]), .inv_in(dbus_in[INV_BIT]),
    .char_code(char_code), .char_inv(char_inv), .video_cycle(video_cycle)
  );

  vf_bus_force #(.DATA_W(DATA_W)) u_force (
    .clk(clk), .rst(rst), .hit(hit), .rd_n(rd_n), .d_in(dbus_in),
    .nop_drive_en(nop_drive_en), .dbus_out(dbus_out)
  );

  vf_chipsel u_cs (
    .clk(clk), .rst(rst), .a14(a14), .mreq_n(mreq_n),
    .romcs_n(romcs_n), .ramcs_n(ramcs_n)
  );

  // R4: a fetch without read strobe never starts a video cycle
  p_iack_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_en && rd_n && !video_cycle) |=> !video_cycle);

  // R5: region limit rejects low-half fetches
  p_restrict_r5: assert property (@(posedge clk) disable iff (rst)
    (sample_en && restrict_en && !a14 && !video_cycle) |=> !video_cycle);

  // R6: no sample strobe, no new video cycle
  p_no_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    (!sample_en && !video_cycle) |=> !video_cycle);
endmodule

// File: tb/video_fetch_nop_test.sv
`timescale 1ns/1ps
module video_fetch_nop_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a15 = 0, a14 = 0, mreq_n = 1, rd_n = 1, m1_n = 1, halt_n = 1;
  logic [7:0] dbus_in = 8'h00;
  logic sample_en = 0, rfsh_done = 0, restrict_en = 0;
  logic nop_drive_en, char_inv, video_cycle, romcs_n, ramcs_n;
  logic [7:0] dbus_out;
  logic [5:0] char_code;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  video_fetch_nop uut (
    .clk(clk), .rst(rst), .a15(a15), .a14(a14), .mreq_n(mreq_n), .rd_n(rd_n),
    .m1_n(m1_n), .halt_n(halt_n), .dbus_in(dbus_in), .sample_en(sample_en),
    .rfsh_done(rfsh_done), .restrict_en(restrict_en), .nop_drive_en(nop_drive_en),
    .dbus_out(dbus_out), .char_code(char_code), .char_inv(char_inv),
    .video_cycle(video_cycle), .romcs_n(romcs_n), .ramcs_n(ramcs_n)
  );

  // {a15,a14,m1_n,rd_n,halt_n,restrict,stb,expect_hit, data[7:0]}
  localparam logic [15:0] VEC [11] = '{
    {8'b10001011, 8'h25},  // R3 plain qualifying fetch
    {8'b10001011, 8'hA3},  // R3/R9 with inverse bit
    {8'b10001010, 8'h45},  // R8 bit6 set: real opcode
    {8'b00001010, 8'h11},  // R3 a15 low
    {8'b10101010, 8'h12},  // R6 m1 already high
    {8'b10011010, 8'h13},  // R4 no read strobe
    {8'b10000010, 8'h14},  // R3 halted
    {8'b10001110, 8'h15},  // R5 restrict, a14 low
    {8'b11001111, 8'h3F},  // R5 restrict, a14 high
    {8'b10001000, 8'h16},  // R6 no strobe
    {8'b11001011, 8'h80}   // R5 a14 ignored when off
  };

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_clear();
    sample_en = 0; rd_n = 1; m1_n = 1; rfsh_done = 1; restrict_en = 0;
    cyc();
    rfsh_done = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [5:0] exp_char;
    logic       exp_inv;
    exp_char = 6'h00; exp_inv = 1'b0;

    cyc(); cyc();
    // R11 reset state
    check("R11 video", {7'd0, video_cycle}, 8'd0);
    check("R11 nop",   {7'd0, nop_drive_en}, 8'd0);
    check("R11 cs",    {6'd0, romcs_n, ramcs_n}, 8'b11);
    check("R11 char",  {1'b0, char_inv, char_code}, 8'd0);
    check("R11 dbus",  dbus_out, 8'd0);
    rst = 0;
    cyc();

    // table walk
    for (int i = 0; i < 11; i++) begin
      logic [15:0] v;
      v = VEC[i];
      a15 = v[15]; a14 = v[14]; m1_n = v[13]; rd_n = v[12]; halt_n = v[11];
      restrict_en = v[10]; sample_en = v[9]; dbus_in = v[7:0];
      cyc();
      if (v[8]) begin exp_char = v[5:0]; exp_inv = v[7]; end
      check($sformatf("R3 vec%0d video", i), {7'd0, video_cycle}, {7'd0, v[8]});
      check($sformatf("R7 vec%0d nop", i), {7'd0, nop_drive_en}, {7'd0, v[8]});
      check($sformatf("R8 vec%0d dbus", i), dbus_out, v[8] ? 8'h00 : v[7:0]);
      check($sformatf("R9 vec%0d char", i), {1'b0, char_inv, char_code}, {1'b0, exp_inv, exp_char});
      halt_n = 1;
      idle_clear();
    end

    // R7 hold while read strobe low, then release
    a15 = 1; a14 = 1; m1_n = 0; rd_n = 0; sample_en = 1; dbus_in = 8'h0A;
    cyc();
    sample_en = 0; dbus_in = 8'h77;
    cyc();
    check("R7 hold nop", {7'd0, nop_drive_en}, 8'd1);
    check("R7 hold data", dbus_out, 8'h00);
    m1_n = 1;
    cyc();
    check("R7 hold nop2", {7'd0, nop_drive_en}, 8'd1);
    rd_n = 1;
    cyc();
    check("R7 release", {7'd0, nop_drive_en}, 8'd0);
    check("R8 after release", dbus_out, 8'h77);
    check("R10 hold flag", {7'd0, video_cycle}, 8'd1);
    rfsh_done = 1;
    cyc();
    rfsh_done = 0;
    check("R10 cleared", {7'd0, video_cycle}, 8'd0);

    // R10 set wins over clear
    m1_n = 0; rd_n = 0; sample_en = 1; rfsh_done = 1; dbus_in = 8'h05;
    cyc();
    check("R10 set priority", {7'd0, video_cycle}, 8'd1);
    check("R9 new char", {2'b0, char_code}, 8'h05);
    idle_clear();

    // R1/R2 chip selects
    a14 = 0; mreq_n = 0;
    cyc();
    check("R1 rom sel", {6'd0, romcs_n, ramcs_n}, 8'b01);
    a14 = 1;
    cyc();
    check("R2 ram sel", {6'd0, romcs_n, ramcs_n}, 8'b10);
    mreq_n = 1;
    cyc();
    check("R2 none", {6'd0, romcs_n, ramcs_n}, 8'b11);

    // R11 reset mid-activity
    m1_n = 0; rd_n = 0; sample_en = 1; dbus_in = 8'h9C; mreq_n = 0;
    cyc();
    sample_en = 0; rst = 1;
    cyc();
    check("R11 mid video", {7'd0, video_cycle}, 8'd0);
    check("R11 mid nop", {7'd0, nop_drive_en}, 8'd0);
    check("R11 mid char", {1'b0, char_inv, char_code}, 8'd0);
    check("R11 mid cs", {6'd0, romcs_n, ramcs_n}, 8'b11);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule